// File: doc/BRIEF.md
# PCI Power-Management Capability Register Pair

This block holds the two configuration-space words of a PCI power-management capability. One is a fixed capabilities word that reports wake signalling from D3hot only. The other is a control/status word. It carries the device power state, a wake enable and a sticky wake status flag. The block also drives the active-low wake event pin.

Configuration reads and writes arrive as a 16-bit word at a byte offset, with one enable per byte lane. The block answers at two fixed offsets. A wake request from the function is accepted only while wake is enabled and the stored state is D3hot. An accepted request sets the status flag and pulls the event pin low. Software releases the pin by writing 1 to the status flag. The pin is also released when the enable is cleared or the device leaves D3hot.

A strap input makes the capability visible or hidden. When it is low, both words read as zero and the block takes no action.

Top module: `pm_cap_regs`

## Requirements
- R1: With the strap at 1, a read at offset 0x46 returns 16'h4000: bits 15:11 are 01000 (wake from D3hot only) and every other bit is 0. Writes to that offset change nothing.
- R2: After synchronous active-low reset with the strap at 1, offset 0x48 reads 16'h8000 and pme_n_o is 1. Bit 15 is status, bit 8 is enable, and bits 1:0 are the power state (00 D0, 01 D1, 10 D2, 11 D3hot).
- R3: Bits 14:9 and 7:2 of the control/status word always read 0, whatever is written to them.
- R4: A write to bits 1:0 stores 00 when the code is 01 or 10, and stores 00 or 11 unchanged. It takes effect only when byte enable 0 is set.
- R5: Bit 8 is a read/write enable. It changes only on a write with byte enable 1 set.
- R6: Writing 1 to bit 15 with byte enable 1 set clears the status flag. Writing 0 leaves it unchanged.
- R7: wake_req_i is sampled on a clock edge. It sets the status flag and drives pme_n_o low after that edge only if the enable is 1 and the state is 11 at that edge. Otherwise it is ignored.
- R8: pme_n_o stays low until status is cleared, the enable is written to 0, or the state is written away from 11. Clearing the enable leaves the status flag set. pme_n_o is never low unless the enable is 1 and the state is 11.
- R9: With the strap at 0, both offsets read 16'h0000, writes are ignored and pme_n_o stays 1.
- R10: Read data is valid in the same cycle as cfg_rd_i. It is 0 when cfg_rd_i is low or the offset matches neither register. Writes take effect on the next rising edge.
- R11: When a wake request is accepted in the same cycle as a status-clear write, the wake request wins: status ends at 1 and pme_n_o goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cap_en_strap_i | input | 1 | Capability visible when 1 |
| cfg_addr_i | input | 8 | Byte offset of the accessed 16-bit word |
| cfg_rd_i | input | 1 | Read strobe |
| cfg_wr_i | input | 1 | Write strobe |
| cfg_be_i | input | 2 | Per-byte write enables |
| cfg_wdata_i | input | 16 | Write data |
| cfg_rdata_o | output | 16 | Read data, combinational |
| wake_req_i | input | 1 | Wake request from the function |
| pme_n_o | output | 1 | Active-low wake event output |

## Verification
Reads are due in the same cycle as the strobe. The bench drives the read on a falling edge and samples one nanosecond later, before the next rising edge. Writes, wake requests and their effect on pme_n_o are due one rising edge after they are driven. Every such stimulus is applied on a falling edge, removed on the next falling edge, and checked at that point, where exactly one register stage has passed. The same-cycle race between a wake request and a status clear is driven within one cycle, so that the priority of R11 is tested rather than the order of two separate cycles.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

   typedef enum logic [1:0] {
      PS_D0    = 2'b00,
      PS_D1    = 2'b01,
      PS_D2    = 2'b10,
      PS_D3HOT = 2'b11
   } pstate_e;

   // bit positions inside the control/status word (decoded by software)
   localparam int STS_BIT = 15;
   localparam int EN_BIT  = 8;
   localparam int PS_LSB  = 0;

   // Only D0 and D3hot exist; the two middle codes land in D0.
   function automatic pstate_e fold_ps(input logic [1:0] code);
      case (code)
         2'b11:   fold_ps = PS_D3HOT;
         default: fold_ps = PS_D0;
      endcase
   endfunction

endpackage

// File: rtl/pmc_decode.sv
module pmc_decode #(
   parameter int                ADDR_W  = 8,
   parameter int                NBYTES  = 2,
   parameter logic [ADDR_W-1:0] CAP_OFS = 8'h46,
   parameter logic [ADDR_W-1:0] CSR_OFS = 8'h48
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              wr_i,
   input  logic              strap_i,
   input  logic [NBYTES-1:0] be_i,
   output logic              cap_sel_o,
   output logic              csr_sel_o,
   output logic [NBYTES-1:0] csr_wbyte_o
);

   assign cap_sel_o = strap_i && (addr_i == CAP_OFS);
   assign csr_sel_o = strap_i && (addr_i == CSR_OFS);

   for (genvar b = 0; b < NBYTES; b++) begin : g_lane
      assign csr_wbyte_o[b] = wr_i && csr_sel_o && be_i[b];
   end

endmodule

// File: rtl/pmc_csr.sv
module pmc_csr
   import pmc_pkg::*;
#(
   parameter int NBYTES    = 2,
   parameter bit SET_WINS  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strap_i,
   input  logic [NBYTES-1:0] wbyte_i,
   input  logic              clr_bit_i,
   input  logic              en_bit_i,
   input  logic [1:0]        ps_code_i,
   input  logic              wake_i,
   output pstate_e           state_o,
   output logic              en_o,
   output logic              status_o,
   output logic              evt_o
);

   localparam int LO_LANE = PS_LSB / 8;
   localparam int HI_LANE = EN_BIT / 8;

   pstate_e state_q, ps_nxt;
   logic    en_q, status_q, evt_q;
   logic    en_nxt, clr, armed, set;
   logic    sts_nxt, evt_src, evt_nxt;

   always_comb begin
      ps_nxt = wbyte_i[LO_LANE] ? fold_ps(ps_code_i) : state_q;
      en_nxt = wbyte_i[HI_LANE] ? en_bit_i : en_q;
      clr    = wbyte_i[HI_LANE] && clr_bit_i;
      armed  = en_q && (state_q == PS_D3HOT);
      set    = wake_i && armed;
   end

   if (SET_WINS) begin : g_set_first
      assign sts_nxt = set || (status_q && !clr);
      assign evt_src = set || (evt_q && !clr);
   end else begin : g_clr_first
      assign sts_nxt = !clr && (set || status_q);
      assign evt_src = !clr && (set || evt_q);
   end

   // event survives only while the next state keeps it armed
   assign evt_nxt = evt_src && en_nxt && (ps_nxt == PS_D3HOT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= PS_D0;
         en_q     <= 1'b0;
         status_q <= strap_i;
         evt_q    <= 1'b0;
      end else if (!strap_i) begin
         state_q  <= PS_D0;
         en_q     <= 1'b0;
         status_q <= 1'b0;
         evt_q    <= 1'b0;
      end else begin
         state_q  <= ps_nxt;
         en_q     <= en_nxt;
         status_q <= sts_nxt;
         evt_q    <= evt_nxt;
      end
   end

   assign state_o  = state_q;
   assign en_o     = en_q;
   assign status_o = status_q;
   assign evt_o    = evt_q;

endmodule

// File: rtl/pmc_rdmux.sv
module pmc_rdmux
   import pmc_pkg::*;
#(
   parameter int         DATA_W   = 16,
   parameter logic [4:0] PME_MASK = 5'b01000
) (
   input  logic              rd_i,
   input  logic              cap_sel_i,
   input  logic              csr_sel_i,
   input  logic              status_i,
   input  logic              en_i,
   input  pstate_e           state_i,
   output logic [DATA_W-1:0] rdata_o
);

   localparam int MASK_LSB = DATA_W - 5;

   logic [DATA_W-1:0] cap_word, csr_word;

   always_comb begin
      cap_word                         = '0;
      cap_word[DATA_W-1:MASK_LSB]      = PME_MASK;
      csr_word                         = '0;
      csr_word[STS_BIT]                = status_i;
      csr_word[EN_BIT]                 = en_i;
      csr_word[PS_LSB+1:PS_LSB]        = state_i;
   end

   always_comb begin
      if (!rd_i)          rdata_o = '0;
      else if (cap_sel_i) rdata_o = cap_word;
      else if (csr_sel_i) rdata_o = csr_word;
      else                rdata_o = '0;
   end

endmodule

// File: rtl/pm_cap_regs.sv
module pm_cap_regs
   import pmc_pkg::*;
#(
   parameter int                ADDR_W   = 8,
   parameter int                DATA_W   = 16,
   parameter logic [ADDR_W-1:0] CAP_OFS  = 8'h46,
   parameter logic [ADDR_W-1:0] CSR_OFS  = 8'h48,
   parameter logic [4:0]        PME_MASK = 5'b01000,
   parameter bit                SET_WINS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_en_strap_i,
   input  logic [ADDR_W-1:0] cfg_addr_i,
   input  logic              cfg_rd_i,
   input  logic              cfg_wr_i,
   input  logic [DATA_W/8-1:0] cfg_be_i,
   input  logic [DATA_W-1:0] cfg_wdata_i,
   output logic [DATA_W-1:0] cfg_rdata_o,
   input  logic              wake_req_i,
   output logic              pme_n_o
);

   localparam int NBYTES = DATA_W / 8;

   if (DATA_W != 16) begin : g_bad_width
      $error("pm_cap_regs: DATA_W must be 16");
   end
   if (CAP_OFS == CSR_OFS) begin : g_bad_ofs
      $error("pm_cap_regs: register offsets must differ");
   end
   if (CAP_OFS[0] || CSR_OFS[0]) begin : g_bad_align
      $error("pm_cap_regs: register offsets must be word aligned");
   end
   if ((PME_MASK & 5'b10111) != 5'b0) begin : g_bad_mask
      $error("pm_cap_regs: wake may only be advertised from D3hot");
   end

   logic              cap_sel, csr_sel;
   logic [NBYTES-1:0] csr_wbyte;
   pstate_e           csr_state;
   logic              csr_en, csr_status, csr_evt;
   logic              unused_wdata;

   assign unused_wdata = ^{cfg_wdata_i[14:9], cfg_wdata_i[7:2]};

   pmc_decode #(
      .ADDR_W (ADDR_W),
      .NBYTES (NBYTES),
      .CAP_OFS(CAP_OFS),
      .CSR_OFS(CSR_OFS)
   ) u_dec (
      .addr_i     (cfg_addr_i),
      .wr_i       (cfg_wr_i),
      .strap_i    (cap_en_strap_i),
      .be_i       (cfg_be_i),
      .cap_sel_o  (cap_sel),
      .csr_sel_o  (csr_sel),
      .csr_wbyte_o(csr_wbyte)
   );

   pmc_csr #(
      .NBYTES  (NBYTES),
      .SET_WINS(SET_WINS)
   ) u_csr (
      .clk      (clk),
      .rst_n    (rst_n),
      .strap_i  (cap_en_strap_i),
      .wbyte_i  (csr_wbyte),
      .clr_bit_i(cfg_wdata_i[STS_BIT]),
      .en_bit_i (cfg_wdata_i[EN_BIT]),
      .ps_code_i(cfg_wdata_i[PS_LSB+1:PS_LSB]),
      .wake_i   (wake_req_i),
      .state_o  (csr_state),
      .en_o     (csr_en),
      .status_o (csr_status),
      .evt_o    (csr_evt)
   );

   pmc_rdmux #(
      .DATA_W  (DATA_W),
      .PME_MASK(PME_MASK)
   ) u_rd (
      .rd_i     (cfg_rd_i),
      .cap_sel_i(cap_sel),
      .csr_sel_i(csr_sel),
      .status_i (csr_status),
      .en_i     (csr_en),
      .state_i  (csr_state),
      .rdata_o  (cfg_rdata_o)
   );

   assign pme_n_o = !(csr_evt && cap_en_strap_i);

endmodule

// File: rtl/pmc_checker.sv
module pmc_checker
   import pmc_pkg::*;
#(
   parameter int                ADDR_W  = 8,
   parameter int                DATA_W  = 16,
   parameter logic [ADDR_W-1:0] CSR_OFS = 8'h48
) (
   input logic                clk,
   input logic                rst_n,
   input logic                strap,
   input logic [ADDR_W-1:0]   addr,
   input logic                rd,
   input logic                wr,
   input logic [DATA_W/8-1:0] be,
   input logic [DATA_W-1:0]   wdata,
   input logic [DATA_W-1:0]   rdata,
   input logic                wake,
   input logic                pme_n,
   input pstate_e             state,
   input logic                en,
   input logic                status
);

   logic hi_wr;
   assign hi_wr = wr && (addr == CSR_OFS) && be[1];

   // R4: the middle power-state codes are never held
   a_r4_no_mid_state: assert property (@(posedge clk) disable iff (!rst_n)
      (state != PS_D1) && (state != PS_D2));

   // R8: the event pin is low only while armed
   a_r8_pme_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
      !pme_n |-> (en && state == PS_D3HOT));

   // R6: a status clear without a competing wake leaves status at 0
   a_r6_w1c: assert property (@(posedge clk) disable iff (!rst_n)
      (strap && hi_wr && wdata[STS_BIT] && !wake) |=> !status);

   // R7: an accepted wake with no write in the same cycle raises status and the pin
   a_r7_wake: assert property (@(posedge clk) disable iff (!rst_n)
      (strap && wake && en && state == PS_D3HOT && !wr) |=> (status && !pme_n));

   // R9: a hidden capability reads zero and never signals
   a_r9_strap_off: assert property (@(posedge clk) disable iff (!rst_n)
      !strap |-> (pme_n && rdata == '0));

   // R10: no read strobe, no data
   a_r10_idle_read: assert property (@(posedge clk) disable iff (!rst_n)
      !rd |-> (rdata == '0));

   // R5: the enable holds without a high-lane write
   a_r5_en_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (strap && !hi_wr) |=> $stable(en));

endmodule

bind pm_cap_regs pmc_checker #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W),
   .CSR_OFS(CSR_OFS)
) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .strap (cap_en_strap_i),
   .addr  (cfg_addr_i),
   .rd    (cfg_rd_i),
   .wr    (cfg_wr_i),
   .be    (cfg_be_i),
   .wdata (cfg_wdata_i),
   .rdata (cfg_rdata_o),
   .wake  (wake_req_i),
   .pme_n (pme_n_o),
   .state (csr_state),
   .en    (csr_en),
   .status(csr_status)
);

// File: tb/pm_cap_regs_bench.sv
module pm_cap_regs_bench;

   localparam logic [7:0] CAP = 8'h46;
   localparam logic [7:0] CSR = 8'h48;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        strap = 1'b1;
   logic [7:0]  addr = '0;
   logic        rd = 1'b0, wr = 1'b0, wake = 1'b0;
   logic [1:0]  be = '0;
   logic [15:0] wdata = '0;
   logic [15:0] rdata;
   logic        pme_n;
   int          n_chk = 0, n_fail = 0;

   always #2 clk = ~clk;

   pm_cap_regs u_pm_cap_regs (
      .clk           (clk),
      .rst_n         (rst_n),
      .cap_en_strap_i(strap),
      .cfg_addr_i    (addr),
      .cfg_rd_i      (rd),
      .cfg_wr_i      (wr),
      .cfg_be_i      (be),
      .cfg_wdata_i   (wdata),
      .cfg_rdata_o   (rdata),
      .wake_req_i    (wake),
      .pme_n_o       (pme_n)
   );

   task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, got, exp);
      end
   endtask

   task automatic do_reset(input logic s);
      @(negedge clk);
      strap = s; rst_n = 1'b0; wr = 1'b0; rd = 1'b0; wake = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic wr16(input logic [7:0] a, input logic [1:0] b, input logic [15:0] d);
      @(negedge clk);
      addr = a; be = b; wdata = d; wr = 1'b1;
      @(negedge clk);
      wr = 1'b0; be = '0;
   endtask

   task automatic rd16(input logic [7:0] a, output logic [15:0] d);
      @(negedge clk);
      addr = a; rd = 1'b1;
      #1 d = rdata;
      rd = 1'b0;
   endtask

   task automatic pulse_wake();
      @(negedge clk);
      wake = 1'b1;
      @(negedge clk);
      wake = 1'b0;
   endtask

   task automatic t_reset_values();
      logic [15:0] d;
      do_reset(1'b1);
      rd16(CAP, d); check("R1 cap word", d, 16'h4000);
      rd16(CSR, d); check("R2 csr reset", d, 16'h8000);
      check("R2 pme_n reset", {15'b0, pme_n}, 16'h0001);
      wr16(CAP, 2'b11, 16'hFFFF);
      rd16(CAP, d); check("R1 cap ignores write", d, 16'h4000);
   endtask

   task automatic t_reserved();
      logic [15:0] d;
      do_reset(1'b1);
      wr16(CSR, 2'b11, 16'h7EFC);
      rd16(CSR, d); check("R3 reserved bits", d, 16'h8000);
   endtask

   task automatic t_fold();
      logic [15:0] d;
      do_reset(1'b1);
      wr16(CSR, 2'b01, 16'h0001);
      rd16(CSR, d); check("R4 code 01 folds", d, 16'h8000);
      wr16(CSR, 2'b01, 16'h0002);
      rd16(CSR, d); check("R4 code 10 folds", d, 16'h8000);
      wr16(CSR, 2'b01, 16'h0003);
      rd16(CSR, d); check("R4 code 11 kept", d, 16'h8003);
      wr16(CSR, 2'b10, 16'h0000);
      rd16(CSR, d); check("R4 lane 0 disabled, R6 zero write", d, 16'h8003);
      wr16(CSR, 2'b01, 16'h0000);
      rd16(CSR, d); check("R4 back to D0", d, 16'h8000);
   endtask

   task automatic t_enable();
      logic [15:0] d;
      do_reset(1'b1);
      wr16(CSR, 2'b10, 16'h0100);
      rd16(CSR, d); check("R5 enable set", d, 16'h8100);
      wr16(CSR, 2'b01, 16'h0000);
      rd16(CSR, d); check("R5 enable needs lane 1", d, 16'h8100);
   endtask

   task automatic t_w1c();
      logic [15:0] d;
      do_reset(1'b1);
      wr16(CSR, 2'b01, 16'h8000);
      rd16(CSR, d); check("R6 clear needs lane 1", d, 16'h8000);
      wr16(CSR, 2'b10, 16'h8000);
      rd16(CSR, d); check("R6 write 1 clears", d, 16'h0000);
   endtask

   task automatic t_wake();
      logic [15:0] d;
      do_reset(1'b1);
      wr16(CSR, 2'b11, 16'h8003);
      pulse_wake();
      rd16(CSR, d); check("R7 ignored when disabled", d, 16'h0003);
      wr16(CSR, 2'b11, 16'h0100);
      pulse_wake();
      rd16(CSR, d); check("R7 ignored in D0", d, 16'h0100);
      check("R7 pin high in D0", {15'b0, pme_n}, 16'h0001);
      wr16(CSR, 2'b11, 16'h0103);
      pulse_wake();
      check("R7 pin low one edge after wake", {15'b0, pme_n}, 16'h0000);
      rd16(CSR, d); check("R7 status set", d, 16'h8103);
      repeat (5) @(negedge clk);
      check("R8 pin held low", {15'b0, pme_n}, 16'h0000);
      wr16(CSR, 2'b11, 16'h8103);
      check("R8 pin released by clear", {15'b0, pme_n}, 16'h0001);
      rd16(CSR, d); check("R6 status cleared", d, 16'h0103);
   endtask

   task automatic t_release();
      logic [15:0] d;
      do_reset(1'b1);
      wr16(CSR, 2'b11, 16'h8103);
      pulse_wake();
      wr16(CSR, 2'b10, 16'h0000);
      check("R8 disable releases pin", {15'b0, pme_n}, 16'h0001);
      rd16(CSR, d); check("R8 status stays set", d, 16'h8003);
      wr16(CSR, 2'b11, 16'h8103);
      pulse_wake();
      wr16(CSR, 2'b01, 16'h0000);
      check("R8 leaving D3hot releases pin", {15'b0, pme_n}, 16'h0001);
      rd16(CSR, d); check("R8 state D0", d, 16'h8100);
   endtask

   task automatic t_race();
      logic [15:0] d;
      do_reset(1'b1);
      wr16(CSR, 2'b11, 16'h8103);
      @(negedge clk);
      addr = CSR; be = 2'b10; wdata = 16'h8100; wr = 1'b1; wake = 1'b1;
      @(negedge clk);
      wr = 1'b0; be = '0; wake = 1'b0;
      check("R11 wake beats clear pin", {15'b0, pme_n}, 16'h0000);
      rd16(CSR, d); check("R11 wake beats clear status", d, 16'h8103);
   endtask

   task automatic t_strap_off();
      logic [15:0] d;
      do_reset(1'b0);
      rd16(CAP, d); check("R9 cap hidden", d, 16'h0000);
      rd16(CSR, d); check("R9 csr hidden", d, 16'h0000);
      wr16(CSR, 2'b11, 16'h0103);
      pulse_wake();
      check("R9 pin stays high", {15'b0, pme_n}, 16'h0001);
      strap = 1'b1;
      rd16(CSR, d); check("R9 write was ignored", d, 16'h0000);
   endtask

   task automatic t_decode();
      logic [15:0] d;
      do_reset(1'b1);
      rd16(8'h44, d); check("R10 unmatched offset", d, 16'h0000);
      @(negedge clk);
      addr = CAP; rd = 1'b0;
      #1 check("R10 no strobe no data", rdata, 16'h0000);
      wr16(8'h4A, 2'b11, 16'h8103);
      rd16(CSR, d); check("R10 other offset write", d, 16'h8000);
   endtask

   initial begin
      #800000;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      t_reset_values();
      t_reserved();
      t_fold();
      t_enable();
      t_w1c();
      t_wake();
      t_release();
      t_race();
      t_strap_off();
      t_decode();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule